// File: doc/BRIEF.md
# Three-Wire Serial Control Register

This block receives a 16-bit control word from a host controller over three wires and holds it in a write-only control register. The three wires are a serial data line, a strobe line, and an active-low frame line. The host lowers the frame line while the strobe is low. It then presents the bits most significant first and raises the strobe once for each bit. After the last bit it raises the frame line again. The shifted word moves into the control register only after the host sends four more strobe pulses once the frame has closed.

All three wires are asynchronous to the system clock. Each passes through a synchronizer before the logic looks for edges. The register drives two decoded two-bit gain selectors, one for the acoustic path and one for the network path. It also drives a one-cycle pulse when it takes a new value. The host cannot read anything back.

Top module: `ser_ctl_reg`

## Requirements
- R1: After reset, `ctrl_o` is 16'h0000, both gain selectors read 2'b00 (0 dB), and `commit_o` is low.
- R2: A frame opens only when `ser_frame_n_i` falls while `ser_strobe_i` is low. A falling edge seen while the strobe is high opens nothing, and a word sent after it is never committed.
- R3: Bits are captured on rising strobe edges, most significant first. The first bit of a frame ends up in bit 15 of the word and the sixteenth bit ends up in bit 0.
- R4: A frame that closes after any bit count other than sixteen (for example 15 or 17) is discarded. No commit follows, even if trailing strobe pulses are sent.
- R5: After a sixteen-bit frame closes, the register updates on the fourth rising strobe edge. After only three trailing edges it still holds its previous value.
- R6: Rising strobe edges while the frame line is high and no word is pending have no effect. This includes edges beyond the fourth trailing edge.
- R7: A new falling edge on the frame line while a word is pending cancels that commit. Only a later complete transfer updates the register.
- R8: `commit_o` is high for exactly one clock cycle, in the same cycle that `ctrl_o` first shows the new word. `ctrl_o` does not change in any other cycle.
- R9: The acoustic gain selector is bits [1:0] of the register and the network gain selector is bits [3:2]. Both use the encoding 2'b00 = 0 dB, 2'b01 = 6 dB, 2'b10 = 9.5 dB, 2'b11 = 12 dB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_data_i | input | 1 | Serial data from the host, asynchronous |
| ser_strobe_i | input | 1 | Bit strobe from the host; data is taken on its rising edge |
| ser_frame_n_i | input | 1 | Active-low frame line from the host |
| ctrl_o | output | 16 | Committed control register |
| aco_gain_o | output | 2 | Acoustic path gain selector |
| net_gain_o | output | 2 | Network path gain selector |
| commit_o | output | 1 | One-cycle pulse when the register takes a new word |

## Verification
Assertions check the following on every cycle:
- `commit_o` is a single-cycle pulse and the register changes only while it is high.
- The shift register holds unless a strobe edge arrives.
- An idle receiver never opens a frame while the strobe is high.
- A short or long frame always falls back to idle.
- The trailing-edge count holds between strobe edges.
- A frame-line fall always leaves the pending state.

Other behaviours need whole transfers, so only the bench scenarios can show them:
- The bit ordering.
- A commit lands on the fourth trailing edge and not the third.
- Cancellation followed by a fresh word.
- Stray strobes are harmless.
- The gain decoding of specific words.

// File: rtl/ser_ctl_pkg.sv
package ser_ctl_pkg;
   localparam int unsigned GAIN_W = 2;

   typedef enum logic [GAIN_W-1:0] {
      GAIN_0DB   = 2'b00,
      GAIN_6DB   = 2'b01,
      GAIN_9P5DB = 2'b10,
      GAIN_12DB  = 2'b11
   } gain_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'b00,
      ST_SHIFT = 2'b01,
      ST_TRAIL = 2'b10
   } rx_state_e;
endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
   parameter int unsigned W       = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] chain [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("sctl_sync: STAGES must be at least 2");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/sctl_frame.sv
module sctl_frame
   import ser_ctl_pkg::*;
#(
   parameter int unsigned WORD_W  = 16,
   parameter int unsigned TRAIL_N = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              data_i,
   input  logic              strobe_i,
   input  logic              frame_n_i,
   output logic [WORD_W-1:0] word_o,
   output logic              commit_stb_o
);
   localparam int unsigned CNT_W = $clog2(WORD_W + 2);
   localparam int unsigned TRL_W = $clog2(TRAIL_N + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);
   localparam logic [TRL_W-1:0] TRL_LAST = TRL_W'(TRAIL_N - 1);

   if (WORD_W < 2) begin : g_bad_word
      $error("sctl_frame: WORD_W must be at least 2");
   end
   if (TRAIL_N < 1) begin : g_bad_trail
      $error("sctl_frame: TRAIL_N must be at least 1");
   end

   logic              str_q, frm_q;
   logic              str_rise, frm_fall, frm_rise;
   rx_state_e         st_q, st_d;
   logic [CNT_W-1:0]  cnt_q, cnt_d;
   logic [TRL_W-1:0]  trl_q, trl_d;
   logic [WORD_W-1:0] sh_q, sh_d;
   logic              commit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         str_q <= 1'b0;
         frm_q <= 1'b1;
      end else begin
         str_q <= strobe_i;
         frm_q <= frame_n_i;
      end
   end

   assign str_rise = strobe_i & ~str_q;
   assign frm_fall = ~frame_n_i & frm_q;
   assign frm_rise = frame_n_i & ~frm_q;

   always_comb begin
      st_d   = st_q;
      cnt_d  = cnt_q;
      trl_d  = trl_q;
      sh_d   = sh_q;
      commit = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (frm_fall && !strobe_i) begin
               st_d  = ST_SHIFT;
               cnt_d = '0;
            end
         end
         ST_SHIFT: begin
            if (frm_rise) begin
               if (cnt_q == CNT_FULL) begin
                  st_d  = ST_TRAIL;
                  trl_d = '0;
               end else begin
                  st_d = ST_IDLE;
               end
            end else if (str_rise) begin
               sh_d = {sh_q[WORD_W-2:0], data_i};
               if (cnt_q != CNT_SAT) cnt_d = cnt_q + 1'b1;
            end
         end
         ST_TRAIL: begin
            if (frm_fall) begin
               cnt_d = '0;
               st_d  = strobe_i ? ST_IDLE : ST_SHIFT;
            end else if (str_rise) begin
               if (trl_q == TRL_LAST) begin
                  commit = 1'b1;
                  st_d   = ST_IDLE;
               end else begin
                  trl_d = trl_q + 1'b1;
               end
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
         trl_q <= '0;
         sh_q  <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
         trl_q <= trl_d;
         sh_q  <= sh_d;
      end
   end

   assign word_o       = sh_q;
   assign commit_stb_o = commit;

   AST_NO_OPEN_STROBE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && strobe_i) |=> (st_q != ST_SHIFT)); // R2
   AST_SHIFT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!str_rise) |=> $stable(sh_q)); // R3
   AST_BAD_COUNT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SHIFT && frm_rise && cnt_q != CNT_FULL) |=> (st_q == ST_IDLE)); // R4
   AST_TRAIL_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_TRAIL && !str_rise && !frm_fall) |=> (st_q == ST_TRAIL && $stable(trl_q))); // R5
   AST_CANCEL_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_TRAIL && frm_fall) |=> (st_q != ST_TRAIL)); // R7
endmodule

// File: rtl/sctl_gain_field.sv
module sctl_gain_field
   import ser_ctl_pkg::*;
#(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned LSB    = 0
) (
   input  logic [WORD_W-1:0] word_i,
   output gain_e             sel_o
);
   if (LSB + GAIN_W > WORD_W) begin : g_bad_lsb
      $error("sctl_gain_field: field does not fit in the word");
   end

   assign sel_o = gain_e'(word_i[LSB +: GAIN_W]);
endmodule

// File: rtl/ser_ctl_reg.sv
module ser_ctl_reg
   import ser_ctl_pkg::*;
#(
   parameter int unsigned WORD_W      = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned TRAIL_N     = 4,
   parameter int unsigned ACO_LSB     = 0,
   parameter int unsigned NET_LSB     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_data_i,
   input  logic              ser_strobe_i,
   input  logic              ser_frame_n_i,
   output logic [WORD_W-1:0] ctrl_o,
   output logic [1:0]        aco_gain_o,
   output logic [1:0]        net_gain_o,
   output logic              commit_o
);
   localparam logic [2:0] SYNC_RST = 3'b100;

   if (GAIN_W != 2) begin : g_bad_gain
      $error("ser_ctl_reg: gain fields must be 2 bits wide");
   end
   if ((ACO_LSB < NET_LSB + GAIN_W) && (NET_LSB < ACO_LSB + GAIN_W)) begin : g_overlap
      $error("ser_ctl_reg: gain fields overlap");
   end

   logic [2:0]        raw_in, syn_in;
   logic [WORD_W-1:0] shift_word;
   logic              commit_stb;
   logic [WORD_W-1:0] ctrl_q;
   logic              commit_q;
   gain_e             aco_sel, net_sel;

   assign raw_in = {ser_frame_n_i, ser_strobe_i, ser_data_i};

   sctl_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYNC_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_in),
      .q_o   (syn_in)
   );

   sctl_frame #(
      .WORD_W  (WORD_W),
      .TRAIL_N (TRAIL_N)
   ) u_frame (
      .clk          (clk),
      .rst_n        (rst_n),
      .data_i       (syn_in[0]),
      .strobe_i     (syn_in[1]),
      .frame_n_i    (syn_in[2]),
      .word_o       (shift_word),
      .commit_stb_o (commit_stb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         commit_q <= 1'b0;
      end else begin
         commit_q <= commit_stb;
         if (commit_stb) ctrl_q <= shift_word;
      end
   end

   sctl_gain_field #(.WORD_W(WORD_W), .LSB(ACO_LSB)) u_aco_field (
      .word_i (ctrl_q),
      .sel_o  (aco_sel)
   );

   sctl_gain_field #(.WORD_W(WORD_W), .LSB(NET_LSB)) u_net_field (
      .word_i (ctrl_q),
      .sel_o  (net_sel)
   );

   assign ctrl_o     = ctrl_q;
   assign commit_o   = commit_q;
   assign aco_gain_o = aco_sel;
   assign net_gain_o = net_sel;

   AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |=> !commit_o); // R8
   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!commit_o) |-> $stable(ctrl_o)); // R8
endmodule

// File: tb/ser_ctl_reg_tb.sv
module ser_ctl_reg_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        data = 1'b0;
   logic        strobe = 1'b0;
   logic        frame_n = 1'b1;
   logic [15:0] ctrl;
   logic [1:0]  aco, net;
   logic        commit;

   int unsigned vectors = 0;
   int unsigned miscompares = 0;
   logic [15:0] exp_q[$];
   logic [15:0] last_word = 16'h0000;
   logic        prev_commit = 1'b0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   ser_ctl_reg u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .ser_data_i    (data),
      .ser_strobe_i  (strobe),
      .ser_frame_n_i (frame_n),
      .ctrl_o        (ctrl),
      .aco_gain_o    (aco),
      .net_gain_o    (net),
      .commit_o      (commit)
   );

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic pulse_strobe();
      strobe = 1'b1; wait_cyc(4);
      strobe = 1'b0; wait_cyc(4);
   endtask

   task automatic open_frame();
      frame_n = 1'b0; wait_cyc(4);
   endtask

   task automatic close_frame();
      frame_n = 1'b1; wait_cyc(4);
   endtask

   task automatic send_bits(input logic [31:0] w, input int n);
      for (int i = 0; i < n; i++) begin
         data = w[n-1-i];
         wait_cyc(3);
         pulse_strobe();
      end
   endtask

   // Full transfer expected to commit: the driver pushes the expected word.
   task automatic good_word(input logic [15:0] w);
      open_frame();
      send_bits({16'h0, w}, 16);
      close_frame();
      for (int t = 0; t < 3; t++) pulse_strobe();
      chk("R5 no commit after 3 trailing edges", ctrl, last_word);
      exp_q.push_back(w);
      pulse_strobe();
      wait_cyc(6);
      last_word = w;
   endtask

   // Monitor: pops expected words on each commit pulse (R8, R9).
   always @(negedge clk) begin
      if (rst_n) begin
         if (commit) begin
            if (prev_commit) begin
               vectors++; miscompares++;
               $display("FAIL R8 commit pulse longer than one cycle: actual 1 expected 0");
            end else if (exp_q.size() == 0) begin
               vectors++; miscompares++;
               $display("FAIL R8 unexpected commit: actual %h expected none", ctrl);
            end else begin
               logic [15:0] e;
               e = exp_q.pop_front();
               chk("R3 R8 committed word", ctrl, e);
               chk("R9 acoustic gain bits [1:0]", {14'h0, aco}, {14'h0, e[1:0]});
               chk("R9 network gain bits [3:2]", {14'h0, net}, {14'h0, e[3:2]});
            end
         end
         prev_commit <= commit;
      end
   end

   task automatic drain(input string tag);
      wait_cyc(8);
      chk(tag, 16'(exp_q.size()), 16'h0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      wait_cyc(5);
      rst_n = 1'b1;
      wait_cyc(3);
      // R1 reset state
      chk("R1 ctrl after reset", ctrl, 16'h0000);
      chk("R1 gains after reset", {12'h0, aco, net}, 16'h0);
      chk("R1 commit after reset", {15'h0, commit}, 16'h0);

      // R3 R5 R9 basic transfers
      good_word(16'hA5C6);
      good_word(16'h000F);        // aco 12 dB, net 12 dB
      good_word(16'h0009);        // aco 6 dB, net 9.5 dB
      drain("R3 all expected commits seen");

      // R4 15-bit and 17-bit frames discarded
      open_frame(); send_bits(32'h7FFF, 15); close_frame();
      for (int t = 0; t < 4; t++) pulse_strobe();
      wait_cyc(6);
      chk("R4 15-bit frame discarded", ctrl, last_word);
      open_frame(); send_bits(32'h1BEEF, 17); close_frame();
      for (int t = 0; t < 4; t++) pulse_strobe();
      wait_cyc(6);
      chk("R4 17-bit frame discarded", ctrl, last_word);

      // R6 idle strobes ignored
      for (int t = 0; t < 6; t++) pulse_strobe();
      wait_cyc(6);
      chk("R6 idle strobes ignored", ctrl, last_word);

      // R2 frame fall while strobe high opens nothing
      strobe = 1'b1; wait_cyc(4);
      frame_n = 1'b0; wait_cyc(4);
      strobe = 1'b0; wait_cyc(4);
      send_bits(32'h3C3C, 16); close_frame();
      for (int t = 0; t < 4; t++) pulse_strobe();
      wait_cyc(6);
      chk("R2 frame with strobe high ignored", ctrl, last_word);

      // R7 pending commit cancelled by new frame carrying a word
      open_frame(); send_bits(32'hDEAD, 16); close_frame();
      pulse_strobe(); pulse_strobe();
      good_word(16'h1234);
      drain("R7 only the later word committed");

      // R7 cancel followed by empty frame, trailing strobes do nothing
      open_frame(); send_bits(32'h5555, 16); close_frame();
      pulse_strobe(); pulse_strobe();
      open_frame(); close_frame();
      for (int t = 0; t < 4; t++) pulse_strobe();
      wait_cyc(6);
      chk("R7 cancelled word not committed", ctrl, last_word);

      // R6 extra trailing strobes after a commit are ignored
      good_word(16'hFFF2);
      pulse_strobe(); pulse_strobe();
      wait_cyc(6);
      chk("R6 extra trailing strobes ignored", ctrl, 16'hFFF2);
      good_word(16'h0000);
      chk("R9 both gains 0 dB", {12'h0, aco, net}, 16'h0);
      drain("R8 commit queue empty at end");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule